// File: doc/BRIEF.md
# Memory-Mapped Peripheral Bus Decoder

This block sits between a 16-bit processor and its 64 KB address space. It looks at the top address bits of every access and steers it to one of three places. Low addresses go to a read-only program store. The middle quarter goes to a small set of peripheral registers held inside this block. The upper half goes to a read/write data memory. The two memory arrays are outside the block; it drives their address and strobe pins and returns their read data to the processor.

The peripheral set has four parts:

- **Serial-input holding byte.** It takes any non-zero character seen on the serial input and empties itself when software reads it.
- **Serial-output port.** It presents each written byte for exactly one cycle.
- **Tick counter.** It counts one-second pulses until software collects and clears it.
- **Display digit bytes.** There are eight of them, one per seven-segment digit.

Read data is combinational from the current state. A clear-on-read takes effect at the clock edge that ends the read cycle.

Top module: `mmio_bus_decoder`

## Requirements
- R1: A read with address bits [15:14] = 00 raises `rom_rd`, presents address bits [13:0] on `rom_addr`, and returns `rom_rdata` on `cpu_rdata`, with no data-memory strobe in that cycle.
- R2: An access with address bit 15 = 1 raises `ram_rd` or `ram_wr` in the same cycle. It presents address bits [14:0] on `ram_addr`, passes `cpu_wdata` and `cpu_word` through, and returns `ram_rdata` on reads.
- R3: A write to the program-store region raises no memory write strobe and changes no peripheral state.
- R4: A non-zero value on `ser_in` is loaded into the serial-input byte at the next clock edge, replacing any earlier value. A zero on `ser_in` leaves the byte unchanged.
- R5: `ser_busy` is high exactly when the serial-input byte is non-zero.
- R6: A read at 0x4100 returns the serial-input byte in bits [7:0] and zeros in bits [15:8]. The byte becomes zero at that edge, unless a non-zero character arrives in the same cycle, in which case it holds that character.
- R7: A write at 0x4102 puts `cpu_wdata[7:0]` on `ser_out` for the single following cycle. In every other cycle `ser_out` is zero.
- R8: Each cycle with `tick` high adds one to a 16-bit tick counter, which wraps from 0xFFFF to 0.
- R9: A read at 0x4000 returns the tick counter. At that edge the counter becomes 1 if `tick` is high in the read cycle, and 0 otherwise.
- R10: A write at 0x4200+k, for k from 0 to 7, sets `seg_digits[8k+7:8k]` to `cpu_wdata[7:0]` and leaves the other digits unchanged.
- R11: A read anywhere else in 0x4000–0x7FFF returns zero. A write anywhere else in that range changes no peripheral state, and `cpu_rdata` is zero whenever `cpu_rd` is low.
- R12: While `rst_n` is low, the serial-input byte, tick counter, serial output and all digits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_word | input | 1 | 1 = word access, 0 = byte access |
| cpu_rdata | output | 16 | Read data to processor |
| rom_addr | output | 14 | Program-store address |
| rom_rd | output | 1 | Program-store read strobe |
| rom_rdata | input | 16 | Program-store read data |
| ram_addr | output | 15 | Data-memory address |
| ram_rd | output | 1 | Data-memory read strobe |
| ram_wr | output | 1 | Data-memory write strobe |
| ram_word | output | 1 | Access size to data memory |
| ram_wdata | output | 16 | Data-memory write data |
| ram_rdata | input | 16 | Data-memory read data |
| ser_in | input | 8 | Incoming serial character, zero when idle |
| ser_busy | output | 1 | Serial-input byte holds a character |
| ser_out | output | 8 | Outgoing serial character strobe |
| tick | input | 1 | Seconds pulse |
| seg_digits | output | 64 | Eight display digit bytes |

## Verification
A wrong decode shows at once, in the same cycle: a strobe appears on the wrong memory, or the read data comes from the wrong source. A fault in the serial-input byte or in a digit byte shows one cycle later, on `ser_busy` or on `seg_digits`. The tick counter has no output of its own, so a lost or doubled tick only shows up as a wrong value at the next read of 0x4000. For this reason the bench reads it often, including in the same cycle as a tick, and right after a full 16-bit wrap.

// File: rtl/mmio_bus_decoder.sv
module mmio_bus_decoder #(
  parameter int TICK_W     = 16,
  parameter int NUM_DIGITS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [15:0]               cpu_addr,
  input  logic [15:0]               cpu_wdata,
  input  logic                      cpu_rd,
  input  logic                      cpu_wr,
  input  logic                      cpu_word,
  output logic [15:0]               cpu_rdata,
  output logic [13:0]               rom_addr,
  output logic                      rom_rd,
  input  logic [15:0]               rom_rdata,
  output logic [14:0]               ram_addr,
  output logic                      ram_rd,
  output logic                      ram_wr,
  output logic                      ram_word,
  output logic [15:0]               ram_wdata,
  input  logic [15:0]               ram_rdata,
  input  logic [7:0]                ser_in,
  output logic                      ser_busy,
  output logic [7:0]                ser_out,
  input  logic                      tick,
  output logic [NUM_DIGITS*8-1:0]   seg_digits
);
  localparam logic [15:0] ADR_TICK   = 16'h4000;
  localparam logic [15:0] ADR_SIN    = 16'h4100;
  localparam logic [15:0] ADR_SOUT   = 16'h4102;
  localparam logic [7:0]  DIG_PAGE   = 8'h42;

  logic sel_rom, sel_io, sel_ram;
  logic rd_tick, rd_sin, wr_sout, wr_dig;
  logic [7:0]        sin_q, sout_q;
  logic [TICK_W-1:0] tick_q;
  logic [NUM_DIGITS*8-1:0] dig_q;
  logic [15:0] io_rdata;

  assign sel_rom = cpu_addr[15:14] == 2'b00;
  assign sel_io  = cpu_addr[15:14] == 2'b01;
  assign sel_ram = cpu_addr[15];

  assign rd_tick = cpu_rd && cpu_addr == ADR_TICK;
  assign rd_sin  = cpu_rd && cpu_addr == ADR_SIN;
  assign wr_sout = cpu_wr && cpu_addr == ADR_SOUT;
  assign wr_dig  = cpu_wr && cpu_addr[15:8] == DIG_PAGE && 32'(cpu_addr[7:0]) < NUM_DIGITS;

  assign rom_addr  = cpu_addr[13:0];
  assign rom_rd    = cpu_rd && sel_rom;
  assign ram_addr  = cpu_addr[14:0];
  assign ram_rd    = cpu_rd && sel_ram;
  assign ram_wr    = cpu_wr && sel_ram;
  assign ram_word  = cpu_word;
  assign ram_wdata = cpu_wdata;

  always_comb begin
    io_rdata = '0;
    if (cpu_addr == ADR_TICK)     io_rdata = 16'(tick_q);
    else if (cpu_addr == ADR_SIN) io_rdata = {8'h00, sin_q};
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_rd) begin
      if (sel_ram)      cpu_rdata = ram_rdata;
      else if (sel_io)  cpu_rdata = io_rdata;
      else              cpu_rdata = rom_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_q  <= '0;
      sout_q <= '0;
      tick_q <= '0;
    end else begin
      if (ser_in != 8'h00) sin_q <= ser_in;
      else if (rd_sin)     sin_q <= '0;
      sout_q <= wr_sout ? cpu_wdata[7:0] : 8'h00;
      if (rd_tick) tick_q <= TICK_W'(tick);
      else         tick_q <= tick_q + TICK_W'(tick);
    end
  end

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dig_q[g*8 +: 8] <= '0;
      else if (wr_dig && cpu_addr[7:0] == 8'(g))
        dig_q[g*8 +: 8] <= cpu_wdata[7:0];
    end
  end

  assign ser_busy   = sin_q != 8'h00;
  assign ser_out    = sout_q;
  assign seg_digits = dig_q;

  AST_ROM_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b00) |-> (!ram_rd && !ram_wr));  // R1
  AST_SOUT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == ADR_SOUT) |=> (ser_out == $past(cpu_wdata[7:0])));  // R7
  AST_SOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr == ADR_SOUT) |=> (ser_out == 8'h00));  // R7
  AST_BUSY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_busy) |-> $past(ser_in != 8'h00));  // R4
  AST_SIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr == ADR_SIN && ser_in == 8'h00) |=> !ser_busy);  // R6
  AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr == ADR_TICK) |=> (tick_q == TICK_W'($past(tick))));  // R9
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cpu_rd && cpu_addr == ADR_TICK) && tick) |=> (tick_q == TICK_W'($past(tick_q) + 1'b1)));  // R8
  AST_ROM_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:14] == 2'b00) |=> $stable(seg_digits));  // R3
endmodule

// File: tb/test_mmio_bus_decoder.sv
module test_mmio_bus_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cpu_addr = '0, cpu_wdata = '0, rom_rdata = '0, ram_rdata = '0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_word = 1'b0, tick = 1'b0;
  logic [7:0] ser_in = '0;
  logic [15:0] cpu_rdata, ram_wdata;
  logic [13:0] rom_addr;
  logic [14:0] ram_addr;
  logic rom_rd, ram_rd, ram_wr, ram_word, ser_busy;
  logic [7:0] ser_out;
  logic [63:0] seg_digits;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0]  m_buf = '0, m_out = '0;
  logic [15:0] m_cnt = '0;
  logic [7:0]  m_dig [8];

  always #4 clk = ~clk;

  mmio_bus_decoder i_mmio_bus_decoder (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_word(cpu_word), .cpu_rdata(cpu_rdata),
    .rom_addr(rom_addr), .rom_rd(rom_rd), .rom_rdata(rom_rdata),
    .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_word(ram_word),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .ser_in(ser_in),
    .ser_busy(ser_busy), .ser_out(ser_out), .tick(tick), .seg_digits(seg_digits));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    logic [63:0] d;
    for (int k = 0; k < 8; k++) d[k*8 +: 8] = m_dig[k];
    chk({req, " R5 busy"}, 64'(ser_busy), 64'(m_buf != 0));
    chk({req, " R7 ser_out"}, 64'(ser_out), 64'(m_out));
    chk({req, " R10 digits"}, seg_digits, d);
  endtask

  task automatic step(input logic rd, input logic wr, input logic word,
                      input logic [15:0] a, input logic [15:0] wd,
                      input logic [7:0] si, input logic tk);
    logic [15:0] exp_rd;
    string tag;
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_word = word; cpu_addr = a; cpu_wdata = wd;
    ser_in = si; tick = tk;
    rom_rdata = a ^ 16'hA5C3; ram_rdata = a ^ 16'h3C5A;
    #1;
    exp_rd = 16'h0000; tag = "R11";
    if (rd) begin
      if (a[15]) begin exp_rd = ram_rdata; tag = "R2"; end
      else if (a[14] == 1'b0) begin exp_rd = rom_rdata; tag = "R1"; end
      else if (a == 16'h4000) begin exp_rd = m_cnt; tag = "R8 R9"; end
      else if (a == 16'h4100) begin exp_rd = {8'h00, m_buf}; tag = "R4 R6"; end
    end
    chk({tag, " rdata"}, 64'(cpu_rdata), 64'(exp_rd));
    chk("R1 rom_rd", 64'(rom_rd), 64'(rd && a[15:14] == 2'b00));
    if (rom_rd) chk("R1 rom_addr", 64'(rom_addr), 64'(a[13:0]));
    chk("R2 ram_rd", 64'(ram_rd), 64'(rd && a[15]));
    chk(a[15:14] == 2'b00 ? "R3 ram_wr" : "R2 ram_wr", 64'(ram_wr), 64'(wr && a[15]));
    if (ram_rd || ram_wr) begin
      chk("R2 ram_addr", 64'(ram_addr), 64'(a[14:0]));
      chk("R2 ram_word", 64'(ram_word), 64'(word));
      chk("R2 ram_wdata", 64'(ram_wdata), 64'(wd));
    end
    @(posedge clk);
    if (si != 0) m_buf = si;
    else if (rd && a == 16'h4100) m_buf = 0;
    if (rd && a == 16'h4000) m_cnt = 16'(tk);
    else m_cnt = m_cnt + 16'(tk);
    m_out = (wr && a == 16'h4102) ? wd[7:0] : 8'h00;
    if (wr && a[15:3] == 13'h0840) m_dig[a[2:0]] = wd[7:0];
    #1;
    chk_state(wr && !a[15] && !(a[15:14] == 2'b01 && (a == 16'h4102 || a[15:3] == 13'h0840))
              ? "R3 R11 ignored" : "R4 R6 R7 R10");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) m_dig[k] = '0;
    ser_in = 8'h55; tick = 1'b1;
    repeat (3) @(negedge clk);
    chk_state("R12 reset");
    ser_in = 8'h00; tick = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    step(1, 0, 1, 16'h4000, 0, 0, 0);                 // R12 counter zero
    step(1, 0, 0, 16'h4100, 0, 0, 0);                 // R12 buffer zero
    step(1, 0, 1, 16'h1234, 0, 0, 0);                 // R1
    step(0, 1, 1, 16'h2000, 16'hBEEF, 0, 0);          // R3
    step(1, 0, 1, 16'h8004, 0, 0, 0);                 // R2
    step(0, 1, 0, 16'hFFFF, 16'h00AA, 0, 0);          // R2
    step(0, 0, 0, 0, 0, 8'h41, 0);                    // R4
    step(0, 0, 0, 0, 0, 8'h42, 0);                    // R4 overwrite
    step(1, 0, 0, 16'h4100, 0, 0, 0);                 // R6 clear
    step(0, 0, 0, 0, 0, 8'h43, 0);
    step(1, 0, 0, 16'h4100, 0, 8'h44, 0);             // R6 arrival wins
    step(1, 0, 0, 16'h4100, 0, 0, 0);
    step(0, 1, 0, 16'h4102, 16'h1158, 0, 0);          // R7
    step(0, 0, 0, 0, 0, 0, 0);                        // R7 back to zero
    step(0, 1, 0, 16'h4102, 16'h0061, 0, 0);
    step(0, 1, 0, 16'h4102, 16'h0062, 0, 0);          // R7 back-to-back
    for (int k = 0; k < 8; k++) step(0, 1, 0, 16'h4200 + 16'(k), 16'(8'h10 + k), 0, 0); // R10
    step(0, 1, 0, 16'h4208, 16'h00FF, 0, 0);          // R11 unmapped
    step(0, 1, 0, 16'h5000, 16'h00FF, 0, 0);          // R11
    step(1, 0, 0, 16'h4101, 0, 0, 0);                 // R11
    repeat (5) step(0, 0, 0, 0, 0, 0, 1);             // R8
    step(1, 0, 1, 16'h4000, 0, 0, 1);                 // R9 tick during read
    step(1, 0, 1, 16'h4000, 0, 0, 0);
    for (int n = 0; n < 65538; n++) step(0, 0, 0, 16'h0000, 0, 0, 1); // R8 wrap
    step(1, 0, 1, 16'h4000, 0, 0, 0);
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      int pick = $urandom_range(0, 9);
      int op = $urandom_range(0, 2);
      case (pick)
        0: a = 16'($urandom_range(0, 16'h3FFF));
        1: a = 16'h8000 | 16'($urandom_range(0, 16'h7FFF));
        2, 3: a = 16'h4000;
        4: a = 16'h4100;
        5: a = 16'h4102;
        6, 7: a = 16'h4200 + 16'($urandom_range(0, 9));
        8: a = 16'h4101;
        default: a = 16'h4000 | 16'($urandom_range(0, 16'h3FFF));
      endcase
      step(op == 1, op == 2, 1'($urandom_range(0, 1)), a, 16'($urandom),
           ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00, 1'($urandom_range(0, 1)));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule